// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

The receiver turns a two-channel serial audio stream into parallel samples. Its inputs are a bit clock, a word clock that selects the channel, and a serial data line. All three are oversampled in the master-clock domain. A rising edge of the bit clock is recognised as a low sample followed by a high sample. On each such edge the data bit is shifted into the word being built. The framing is chosen by a static input. One setting delays the most significant bit by one bit-clock slot after the word clock changes, which is I2S framing. The other setting places the most significant bit on the first slot, which is left-justified framing. Each complete left/right pair is presented on two 24-bit buses with a one-cycle strobe.

In parallel, the block counts master-clock cycles between rising edges of the word clock. It compares the count with the selected master-clock ratio of 256 or 384 times the sample rate. When the count does not match, or when the word clock stops, it raises an invalid flag so that a downstream stage can mute the output. The flag is released only after the stream has been well-formed for two whole periods in a row.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is active and right after it is released, both sample buses are zero, the strobe is low and the invalid flag is high.
- R2: With the format input at 0, a word's MSB is taken on the second bit-clock rising edge after the word clock changes level, and word-clock low marks the left channel.
- R3: With the format input at 1, a word's MSB is taken on the first bit-clock rising edge after the word clock changes level, and word-clock high marks the left channel.
- R4: Samples are 24 bits and MSB first. Slots after the 24th in a half-frame do not change the sample.
- R5: A word shorter than 24 bits lands in the upper bits of the sample, and the unused low bits read zero.
- R6: A pair is presented only once its right word is complete. The pair is finished when the MSB of the next left word is taken. The strobe is high for exactly one master-clock cycle, two cycles after the bit-clock rising edge that carries that MSB is applied at the input. Between strobes the buses hold their values.
- R7: Select 0 expects 256 master-clock cycles per word-clock period and select 1 expects 384. A measured period that differs from the expected value by more than 2 cycles sets the invalid flag.
- R8: The first word-clock rising edge after reset only starts a measurement. The invalid flag clears on the second consecutive well-formed period, and not before.
- R9: If no word-clock rising edge arrives within the expected period plus 2 cycles of the previous one, the invalid flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all inputs are sampled on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 1 | Framing: 0 one-slot delay (I2S), 1 left-justified |
| ratio_sel_i | input | 1 | Master-clock ratio: 0 = 256, 1 = 384 times fs |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample of the last complete pair |
| right_o | output | 24 | Right sample of the last complete pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| invalid_o | output | 1 | Word-clock period is out of range |

## Verification
Each bit-clock rising edge passes through one input register and then one output register, so a pair strobe is due exactly two master-clock cycles after the bench applies the rising edge that carries the next left MSB. The driver records that cycle number when it applies the edge, and the monitor compares both the cycle and the pair contents when the strobe appears. The invalid flag can change only two cycles after a word-clock rising edge, or at the timeout. The bench therefore samples it at the middle of each left half, well away from any word-clock edge, and checks it against the count of good periods seen so far. It sweeps both framings, both ratios, 16-, 24- and 32-slot half-frames, and all-ones and all-zeros words.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned RATIO_LO  = 256;
  localparam int unsigned RATIO_HI  = 384;
  localparam int unsigned RATIO_TOL = 2;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } fmt_e;
endpackage

// File: rtl/sar_in_sync.sv
`timescale 1ns/1ps
module sar_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic wclk_o,
  output logic sdata_o
);
  logic b_q, b_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q     <= 1'b0;
      b_d     <= 1'b0;
      wclk_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      b_q     <= bclk_i;
      b_d     <= b_q;
      wclk_o  <= wclk_i;
      sdata_o <= sdata_i;
    end
  end

  assign rise_o = b_q & ~b_d;

  // R6
  rise_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sar_deser.sv
`timescale 1ns/1ps
module sar_deser #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              rise_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam int unsigned     POS_W    = $clog2(WORD_W + 1);
  localparam logic [POS_W-1:0] POS_FULL = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] POS_TOP  = POS_W'(WORD_W - 1);

  logic              w_prev, seen, pend, live, acc_left, left_ok;
  logic [WORD_W-1:0] acc, left_hold;
  logic [POS_W-1:0]  pos, bit_idx;
  logic              trans, commit, new_left, is_lj;

  always_comb begin
    is_lj    = (fmt_i == sar_pkg::FMT_LJ);
    trans    = seen & (wclk_i ^ w_prev);
    // left-justified starts a word on the change itself, I2S one slot later
    commit   = is_lj ? trans : pend;
    new_left = is_lj ? wclk_i : ~wclk_i;
    bit_idx  = POS_TOP - pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_prev    <= 1'b0;
      seen      <= 1'b0;
      pend      <= 1'b0;
      live      <= 1'b0;
      acc_left  <= 1'b0;
      left_ok   <= 1'b0;
      acc       <= '0;
      left_hold <= '0;
      pos       <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        seen   <= 1'b1;
        w_prev <= wclk_i;
        pend   <= ~is_lj & trans;
        if (commit) begin
          if (live) begin
            if (acc_left) begin
              left_hold <= acc;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              left_o  <= left_hold;
              right_o <= acc;
              valid_o <= 1'b1;
              left_ok <= 1'b0;
            end
          end
          acc      <= {sdata_i, {(WORD_W-1){1'b0}}};
          pos      <= POS_W'(1);
          acc_left <= new_left;
          live     <= 1'b1;
        end else if (pos < POS_FULL) begin
          acc[bit_idx] <= sdata_i;
          pos          <= pos + POS_W'(1);
        end
      end
    end
  end

  // R6
  valid_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));
  // R6
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o || ($stable(left_o) && $stable(right_o))));
  // R4
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos <= POS_FULL);
endmodule

// File: rtl/sar_rate_chk.sv
`timescale 1ns/1ps
module sar_rate_chk #(
  parameter int unsigned RATIO_LO  = 256,
  parameter int unsigned RATIO_HI  = 384,
  parameter int unsigned RATIO_TOL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ratio_sel_i,
  input  logic wclk_i,
  output logic invalid_o
);
  localparam int unsigned CNT_MAX = RATIO_HI + RATIO_TOL + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W:0] LO_MIN = (CNT_W+1)'(RATIO_LO - RATIO_TOL);
  localparam logic [CNT_W:0] LO_MAX = (CNT_W+1)'(RATIO_LO + RATIO_TOL);
  localparam logic [CNT_W:0] HI_MIN = (CNT_W+1)'(RATIO_HI - RATIO_TOL);
  localparam logic [CNT_W:0] HI_MAX = (CNT_W+1)'(RATIO_HI + RATIO_TOL);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CNT_MAX);

  logic             w_d, armed, timed_out, w_rise, good;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period, r_min, r_max;
  logic [1:0]       good_cnt;

  always_comb begin
    w_rise = wclk_i & ~w_d;
    r_min  = ratio_sel_i ? HI_MIN : LO_MIN;
    r_max  = ratio_sel_i ? HI_MAX : LO_MAX;
    period = {1'b0, cnt} + (CNT_W+1)'(1);
    good   = (period >= r_min) && (period <= r_max) && !timed_out;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_d       <= 1'b0;
      armed     <= 1'b0;
      timed_out <= 1'b0;
      cnt       <= '0;
      good_cnt  <= '0;
      invalid_o <= 1'b1;
    end else begin
      w_d <= wclk_i;
      if (w_rise) begin
        cnt       <= '0;
        armed     <= 1'b1;
        timed_out <= 1'b0;
        if (armed) begin
          if (good) begin
            if (good_cnt != 2'd0) begin
              good_cnt  <= 2'd2;
              invalid_o <= 1'b0;
            end else begin
              good_cnt <= 2'd1;
            end
          end else begin
            good_cnt  <= '0;
            invalid_o <= 1'b1;
          end
        end
      end else begin
        if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
        if (armed && !timed_out && ({1'b0, cnt} == r_max)) begin
          timed_out <= 1'b1;
          good_cnt  <= '0;
          invalid_o <= 1'b1;
        end
      end
    end
  end

  // R8
  clear_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalid_o) |-> $past(w_rise));
  // R8
  clear_after_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalid_o) |-> $past(good_cnt == 2'd1));
  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_SAT);
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
  parameter int unsigned WORD_W    = sar_pkg::WORD_W,
  parameter int unsigned RATIO_LO  = sar_pkg::RATIO_LO,
  parameter int unsigned RATIO_HI  = sar_pkg::RATIO_HI,
  parameter int unsigned RATIO_TOL = sar_pkg::RATIO_TOL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              ratio_sel_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              invalid_o
);
  logic rise, wclk_s, sdata_s;

  sar_in_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .wclk_i  (wclk_i),
    .sdata_i (sdata_i),
    .rise_o  (rise),
    .wclk_o  (wclk_s),
    .sdata_o (sdata_s)
  );

  sar_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt_i),
    .rise_i  (rise),
    .wclk_i  (wclk_s),
    .sdata_i (sdata_s),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

  sar_rate_chk #(
    .RATIO_LO  (RATIO_LO),
    .RATIO_HI  (RATIO_HI),
    .RATIO_TOL (RATIO_TOL)
  ) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_sel_i (ratio_sel_i),
    .wclk_i      (wclk_s),
    .invalid_o   (invalid_o)
  );
endmodule

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fmt = 1'b0, sel = 1'b0, bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, invalid_o;

  int checks = 0, failures = 0, cyc = 0;
  int exp_cyc [64];
  logic [23:0] exp_l [64], exp_r [64];
  int wr = 0, rd = 0;
  string cur_tag = "R2";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .ratio_sel_i(sel),
    .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .invalid_o(invalid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_w(input logic [31:0] w, input int s);
    return (s >= 32) ? w : (w & ((32'h1 << s) - 32'h1));
  endfunction

  function automatic logic [23:0] exp_word(input logic [31:0] w, input int s);
    logic [31:0] m = mask_w(w, s);
    if (s >= 24) return 24'(m >> (s - 24));
    return 24'(m << (24 - s));
  endfunction

  // half 0: preamble (right), halves 1..2n: frames, half 2n+1: trailing left
  function automatic logic [31:0] word_of(input int i, input int n, input int s, input int seed);
    logic [31:0] w;
    int f = (i - 1) / 2;
    if (i == 0 || i == 2*n + 1) w = 32'hA5C3_96E1;
    else if (f == 0) w = (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
    else if (f == 1) w = (i % 2 == 1) ? 32'h8000_0001 : 32'h7FFF_FFFE;
    else w = (32'h9E37_79B9 * 32'(i + seed)) ^ (32'(i) << 7);
    return mask_w(w, s);
  endfunction

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (rd == wr) begin
        chk(1'b0, "R6", "unexpected strobe", {8'h0, left_o}, 32'h0);
      end else begin
        chk(cyc == exp_cyc[rd], "R6", "strobe cycle", 32'(cyc), 32'(exp_cyc[rd]));
        chk(left_o == exp_l[rd], cur_tag, "left", {8'h0, left_o}, {8'h0, exp_l[rd]});
        chk(right_o == exp_r[rd], cur_tag, "right", {8'h0, right_o}, {8'h0, exp_r[rd]});
        rd++;
      end
    end
  end

  task automatic do_reset(input logic fm, input logic sl);
    rst_ni = 1'b0;
    fmt = fm; sel = sl; bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
    wr = 0; rd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_stream(input logic fm, input logic sl, input int s, input int h,
                            input int n, input int seed, input string tag, input bit rate_ok);
    logic lvl_left;
    do_reset(fm, sl);
    cur_tag = tag;
    lvl_left = fm;
    for (int i = 0; i <= 2*n + 1; i++) begin
      logic [31:0] wcur, wprev;
      wcur  = word_of(i, n, s, seed);
      wprev = (i == 0) ? 32'h0 : word_of(i - 1, n, s, seed);
      for (int j = 0; j < s; j++) begin
        logic b;
        if (fm) b = wcur[s-1-j];
        else    b = (j == 0) ? wprev[0] : wcur[s-j];
        bclk = 1'b0;
        wclk = (i % 2 == 1) ? lvl_left : ~lvl_left;
        sdata = b;
        repeat (h) @(negedge clk);
        bclk = 1'b1;
        if ((i % 2 == 1) && i >= 3 && (fm ? (j == 0) : (j == 1))) begin
          exp_cyc[wr] = cyc + 2;
          exp_l[wr]   = exp_word(word_of(i - 2, n, s, seed), s);
          exp_r[wr]   = exp_word(word_of(i - 1, n, s, seed), s);
          wr++;
        end
        if ((i % 2 == 1) && i <= 2*n - 1 && j == s / 2) begin
          bit e = rate_ok ? (((i - 1) / 2) < 2) : 1'b1;
          // R7 R8: flag tracks the number of good periods so far
          chk(invalid_o == e, rate_ok ? "R8" : "R7", "invalid mid-frame",
              {31'h0, invalid_o}, {31'h0, e});
        end
        repeat (h) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk(wr == rd, "R6", "strobes seen", 32'(rd), 32'(wr));
    chk(wr == n, "R6", "pairs expected", 32'(wr), 32'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    // R1
    chk(left_o == 24'h0, "R1", "left after reset", {8'h0, left_o}, 32'h0);
    chk(right_o == 24'h0, "R1", "right after reset", {8'h0, right_o}, 32'h0);
    chk(valid_o == 1'b0, "R1", "strobe after reset", {31'h0, valid_o}, 32'h0);
    chk(invalid_o == 1'b1, "R1", "invalid after reset", {31'h0, invalid_o}, 32'h1);

    // R2 R4: one-slot delay, 32-slot halves, 256 ratio
    run_stream(1'b0, 1'b0, 32, 2, 4, 3, "R2 R4", 1'b1);
    // R3 R4: no delay, 32-slot halves, 256 ratio
    run_stream(1'b1, 1'b0, 32, 2, 4, 11, "R3 R4", 1'b1);
    // R9: word clock stops after a good stream
    chk(invalid_o == 1'b0, "R8", "valid before stall", {31'h0, invalid_o}, 32'h0);
    repeat (450) @(negedge clk);
    chk(invalid_o == 1'b1, "R9", "stalled word clock", {31'h0, invalid_o}, 32'h1);
    // R3 R7: exact 24-slot halves at 384 ratio
    run_stream(1'b1, 1'b1, 24, 4, 4, 29, "R3 R7", 1'b1);
    // R5: 16-bit words, one-slot delay
    run_stream(1'b0, 1'b0, 16, 4, 4, 41, "R5", 1'b1);
    // R5: 16-bit words, no delay
    run_stream(1'b1, 1'b0, 16, 4, 3, 57, "R5", 1'b1);
    // R7: 256-cycle periods against a 384 select
    run_stream(1'b0, 1'b1, 32, 2, 4, 73, "R7", 1'b0);
    // R7: 384-cycle periods against a 256 select
    run_stream(1'b1, 1'b0, 24, 4, 3, 89, "R7", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule